// File: doc/BRIEF.md
# Root Clock Generator with Fractional Divider

This block derives one root clock from up to eight source clocks. A source selector picks one source. A pre-divider then divides it by an integer or half-integer ratio. A fractional M/N accumulator can follow the pre-divider, and a threshold sets its duty cycle. In this model the sources are slow square waves that are sampled in the block's system clock domain. Every edge of the selected source, rising or falling, counts as one half-period tick. The generated root clock is a registered level, `out_clk`.

Software programs the block over a simple register bus into shadow registers. These are a configuration word, the M value, the inverted N−M value and the inverted duty threshold. None of these values affects the output until software sets the update request bit in the command register. The hardware then copies the shadow set into the active set and hands the output over to the new source. The handover happens only once both the old and the new source are low. The hardware clears the request bit when the handover is complete. A root-off status bit reports when no clock is being produced.

Top module: `root_clk_gen`

## Requirements
- R1: While `rst` is high and after it falls, `out_clk` is 0, and the command and configuration registers read 0.
- R2: The address map is 0 = command, 1 = configuration, 2 = M, 3 = inverted N−M, 4 = inverted duty threshold. `rd_data` returns the register selected by `addr` one cycle later. The configuration word keeps only bits 4:0 (pre-divide code), 10:8 (source), 13:12 (mode) and 20 (hardware gating); all other bits read 0.
- R3: Writing 1 to command bit 0 sets the update request. The active configuration changes only while a request is pending. Bit 0 reads 1 until the new source has taken over, and then reads 0.
- R4: A pre-divide code c gives an output period of (c+1) source half-periods. The output is high for the first ceil((c+1)/2) of them. Code 0 bypasses the pre-divider and behaves like code 1.
- R5: Configuration bits 10:8 select source 0..7. The handover to a new source waits until both the old and the new source are low.
- R6: With mode 2 and a nonzero N−M, the accumulator adds M modulo N = (N−M)+M once per pre-divider period. For that whole period the output is high when the new accumulator value is below the duty threshold. In any other mode, or with N−M equal to 0, the accumulator is bypassed.
- R7: When configuration bit 20 is set and `hw_req` is low, `out_clk` is held low and command bit 31 reads 1.
- R8: While a source handover is pending, `out_clk` is held low and command bit 31 reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_clk | input | NSRC | Source clock levels |
| hw_req | input | 1 | Hardware clock request used when gating is enabled |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Registered read data |
| out_clk | output | 1 | Generated root clock |

## Verification
Read data is due one cycle after the address is presented. The bench therefore sets the address on one falling edge and samples on the next. A freshly written update request shows on the first read after the write and clears no earlier than two cycles after it, so completion is observed by bounded polling of bit 0. The output is registered one cycle behind the divider counters and restarts on every update. Each waveform check therefore skips two rising edges and then measures period and high time in whole system cycles, which makes the result independent of start-up phase. Holds during a handover or gating are checked across tens of cycles while the source is frozen high or `hw_req` is low.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
  localparam int unsigned SELW = 3;
  localparam int unsigned DIV_LSB = 0;
  localparam int unsigned SRC_LSB = 8;
  localparam int unsigned MODE_LSB = 12;
  localparam int unsigned GATE_BIT = 20;
  localparam int unsigned UPD_BIT = 0;
  localparam int unsigned OFF_BIT = 31;
  localparam logic [1:0] MODE_DUAL = 2'd2;

  typedef enum logic [2:0] {
    A_CMD  = 3'd0,
    A_CFG  = 3'd1,
    A_MVAL = 3'd2,
    A_NINV = 3'd3,
    A_DINV = 3'd4
  } rcg_addr_e;

  typedef struct packed {
    logic            hw_ctl;
    logic [1:0]      mode;
    logic [SELW-1:0] src;
    logic [4:0]      pdiv;
  } rcg_cfg_t;

  function automatic rcg_cfg_t cfg_from_word(logic [31:0] w);
    rcg_cfg_t c;
    c.hw_ctl = w[GATE_BIT];
    c.mode   = w[MODE_LSB +: 2];
    c.src    = w[SRC_LSB +: SELW];
    c.pdiv   = w[DIV_LSB +: 5];
    return c;
  endfunction

  function automatic logic [31:0] cfg_to_word(rcg_cfg_t c);
    logic [31:0] w;
    w = '0;
    w[GATE_BIT]         = c.hw_ctl;
    w[MODE_LSB +: 2]    = c.mode;
    w[SRC_LSB +: SELW]  = c.src;
    w[DIV_LSB +: 5]     = c.pdiv;
    return w;
  endfunction
endpackage

// File: rtl/rcg_regs.sv
module rcg_regs
  import rcg_pkg::*;
#(
  parameter int unsigned MNDW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [2:0]      addr,
  input  logic [31:0]     wr_data,
  input  logic            busy,
  input  logic            root_off,
  output logic [31:0]     rd_data,
  output rcg_cfg_t        act_cfg,
  output logic [MNDW-1:0] act_m,
  output logic [MNDW-1:0] act_n,
  output logic [MNDW-1:0] act_d,
  output logic            upd,
  output logic            apply
);
  rcg_cfg_t        sh_cfg;
  logic [MNDW-1:0] sh_m, sh_n, sh_d;
  logic            applied;
  logic            unused_wr;

  assign unused_wr = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_cfg  <= '0;
      sh_m    <= '0;
      sh_n    <= '0;
      sh_d    <= '0;
      act_cfg <= '0;
      act_m   <= '0;
      act_n   <= '0;
      act_d   <= '0;
      upd     <= 1'b0;
      applied <= 1'b0;
      apply   <= 1'b0;
      rd_data <= '0;
    end else begin
      apply <= 1'b0;
      // handshake: load the active set once, then wait for the handover
      if (upd && !applied) begin
        act_cfg <= sh_cfg;
        act_m   <= sh_m;
        act_n   <= sh_n;
        act_d   <= sh_d;
        applied <= 1'b1;
        apply   <= 1'b1;
      end else if (upd && applied && !busy) begin
        upd     <= 1'b0;
        applied <= 1'b0;
      end
      if (wr_en) begin
        case (rcg_addr_e'(addr))
          A_CMD:  if (wr_data[UPD_BIT]) begin
                    upd     <= 1'b1;
                    applied <= 1'b0;
                  end
          A_CFG:  sh_cfg <= cfg_from_word(wr_data);
          A_MVAL: sh_m   <= wr_data[MNDW-1:0];
          A_NINV: sh_n   <= wr_data[MNDW-1:0];
          A_DINV: sh_d   <= wr_data[MNDW-1:0];
          default: ;
        endcase
      end
      case (rcg_addr_e'(addr))
        A_CMD:   rd_data <= {root_off, 30'd0, upd};
        A_CFG:   rd_data <= cfg_to_word(sh_cfg);
        A_MVAL:  rd_data <= 32'(sh_m);
        A_NINV:  rd_data <= 32'(sh_n);
        A_DINV:  rd_data <= 32'(sh_d);
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/rcg_src_mux.sv
module rcg_src_mux
  import rcg_pkg::*;
#(
  parameter int unsigned NSRC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_clk,
  input  logic [SELW-1:0] tgt,
  output logic            sel_lvl,
  output logic            busy
);
  localparam int unsigned NPAD = 1 << SELW;

  logic [NSRC-1:0] src_s;
  logic [NPAD-1:0] pad;
  logic [SELW-1:0] cur;

  generate
    if (NSRC < NPAD) begin : g_pad
      assign pad = {{(NPAD-NSRC){1'b0}}, src_s};
    end else begin : g_full
      assign pad = src_s[NPAD-1:0];
    end
  endgenerate

  assign busy    = (cur != tgt);
  assign sel_lvl = pad[cur];

  always_ff @(posedge clk) begin
    if (rst) begin
      src_s <= '0;
      cur   <= '0;
    end else begin
      src_s <= src_clk;
      if (busy && !pad[cur] && !pad[tgt]) cur <= tgt;
    end
  end
endmodule

// File: rtl/rcg_divider.sv
module rcg_divider
  import rcg_pkg::*;
#(
  parameter int unsigned MNDW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sel_lvl,
  input  logic            apply,
  input  logic            hold,
  input  logic            gate,
  input  logic [4:0]      pdiv,
  input  logic [1:0]      mode,
  input  logic [MNDW-1:0] m,
  input  logic [MNDW-1:0] n,
  input  logic [MNDW-1:0] d,
  output logic            out_clk
);
  localparam int unsigned AW = MNDW + 1;

  logic            prev, tick, mnd_on, mnd_lvl;
  logic [4:0]      h;
  logic [5:0]      span, last, hi_len;
  logic [MNDW-1:0] nm_raw, d_thr;
  logic [AW-1:0]   n_dec, acc, acc_nxt;
  logic [AW:0]     acc_sum, acc_dif;

  assign span    = (pdiv == 5'd0) ? 6'd2 : {1'b0, pdiv} + 6'd1;
  assign last    = span - 6'd1;
  assign hi_len  = (span + 6'd1) >> 1;
  assign nm_raw  = ~n;
  assign d_thr   = ~d;
  assign n_dec   = {1'b0, nm_raw} + {1'b0, m};
  assign mnd_on  = (mode == MODE_DUAL) && (nm_raw != '0);
  assign acc_sum = {1'b0, acc} + {2'b0, m};
  assign acc_dif = acc_sum - {1'b0, n_dec};
  assign acc_nxt = (acc_sum >= {1'b0, n_dec}) ? acc_dif[AW-1:0] : acc_sum[AW-1:0];
  assign tick    = (sel_lvl != prev) && !hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev    <= 1'b0;
      h       <= '0;
      acc     <= '0;
      mnd_lvl <= 1'b0;
      out_clk <= 1'b0;
    end else begin
      prev <= sel_lvl;
      if (apply) begin
        h       <= '0;
        acc     <= '0;
        mnd_lvl <= 1'b0;
      end else if (tick) begin
        if ({1'b0, h} == last) begin
          h <= '0;
          if (mnd_on) begin
            acc     <= acc_nxt;
            mnd_lvl <= (acc_nxt < {1'b0, d_thr});
          end
        end else begin
          h <= h + 5'd1;
        end
      end
      if (hold || gate) out_clk <= 1'b0;
      else if (mnd_on)  out_clk <= mnd_lvl;
      else              out_clk <= ({1'b0, h} < hi_len);
    end
  end
endmodule

// File: rtl/root_clk_gen.sv
module root_clk_gen
  import rcg_pkg::*;
#(
  parameter int unsigned NSRC = 8,
  parameter int unsigned MNDW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_clk,
  input  logic            hw_req,
  input  logic            wr_en,
  input  logic [2:0]      addr,
  input  logic [31:0]     wr_data,
  output logic [31:0]     rd_data,
  output logic            out_clk
);
  rcg_cfg_t        act_cfg;
  logic [MNDW-1:0] act_m, act_n, act_d;
  logic            upd, apply, busy, gate, root_off, sel_lvl;

  assign gate     = act_cfg.hw_ctl && !hw_req;
  assign root_off = busy || gate;

  rcg_regs #(.MNDW(MNDW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .busy(busy), .root_off(root_off), .rd_data(rd_data), .act_cfg(act_cfg),
    .act_m(act_m), .act_n(act_n), .act_d(act_d), .upd(upd), .apply(apply)
  );

  rcg_src_mux #(.NSRC(NSRC)) u_mux (
    .clk(clk), .rst(rst), .src_clk(src_clk), .tgt(act_cfg.src),
    .sel_lvl(sel_lvl), .busy(busy)
  );

  rcg_divider #(.MNDW(MNDW)) u_div (
    .clk(clk), .rst(rst), .sel_lvl(sel_lvl), .apply(apply), .hold(busy),
    .gate(gate), .pdiv(act_cfg.pdiv), .mode(act_cfg.mode), .m(act_m),
    .n(act_n), .d(act_d), .out_clk(out_clk)
  );
endmodule

// File: rtl/rcg_checker.sv
module rcg_checker
  import rcg_pkg::*;
(
  input logic     clk,
  input logic     rst,
  input logic     busy,
  input logic     gate,
  input logic     upd,
  input logic     sel_lvl,
  input logic     out_clk,
  input rcg_cfg_t act_cfg
);
  p_hold_low_r8: assert property (@(posedge clk) disable iff (rst)
    busy |=> !out_clk);

  p_gate_low_r7: assert property (@(posedge clk) disable iff (rst)
    gate |=> !out_clk);

  p_upd_waits_r3: assert property (@(posedge clk) disable iff (rst)
    (upd && busy) |=> upd);

  p_cfg_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(act_cfg));

  p_handover_low_r5: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && $stable(act_cfg.src)) |-> !$past(sel_lvl));
endmodule

bind root_clk_gen rcg_checker u_chk (
  .clk(clk), .rst(rst), .busy(busy), .gate(gate), .upd(upd),
  .sel_lvl(sel_lvl), .out_clk(out_clk), .act_cfg(act_cfg)
);

// File: tb/tb_root_clk_gen.sv
module tb_root_clk_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  src_clk = '0;
  logic        hw_req = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        out_clk;
  logic        freeze5 = 1'b0;
  int          total = 0;
  int          bad = 0;

  typedef struct { int per; int hi; string tag; } shape_t;
  shape_t exp_q[$];

  root_clk_gen dut (
    .clk(clk), .rst(rst), .src_clk(src_clk), .hw_req(hw_req), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .out_clk(out_clk)
  );

  always #4 clk = ~clk;

  // source i toggles every i+2 system cycles; source 5 can be frozen high
  initial begin : sources
    int cnt [8];
    for (int i = 0; i < 8; i++) cnt[i] = 0;
    forever begin
      @(negedge clk);
      for (int i = 0; i < 8; i++) begin
        cnt[i]++;
        if (cnt[i] >= i + 2) begin
          cnt[i] = 0;
          src_clk[i] = ~src_clk[i];
        end
      end
      if (freeze5) src_clk[5] = 1'b1;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic wait_done(int limit, output int ok);
    logic [31:0] v;
    ok = 0;
    for (int k = 0; k < limit; k++) begin
      rd(3'd0, v);
      if (!v[0]) begin ok = 1; break; end
    end
  endtask

  task automatic expect_shape(int per, int hi, string tag);
    shape_t s;
    s.per = per; s.hi = hi; s.tag = tag;
    exp_q.push_back(s);
    wait (exp_q.size() == 0);
  endtask

  task automatic low_for(int n, string tag);
    int seen;
    seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (out_clk) seen++;
    end
    chk(tag, seen, 0);
  endtask

  // monitor: skips two rising edges, then measures one full period
  initial begin : monitor
    shape_t it;
    logic p;
    int per, hi;
    forever begin
      wait (exp_q.size() != 0);
      it = exp_q[0];
      for (int r = 0; r < 2; r++) begin
        p = out_clk;
        forever begin
          @(negedge clk);
          if (out_clk && !p) break;
          p = out_clk;
        end
      end
      per = 0; hi = 0; p = 1'b1;
      forever begin
        per++;
        if (p) hi++;
        @(negedge clk);
        if (out_clk && !p) break;
        p = out_clk;
      end
      chk({it.tag, " period"}, per, it.per);
      chk({it.tag, " high"}, hi, it.hi);
      void'(exp_q.pop_front());
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    logic [31:0] v;
    int ok;
    repeat (4) @(negedge clk);
    chk("R1 out in reset", int'(out_clk), 0);
    rst = 1'b0;
    rd(3'd0, v); chk("R1 cmd after reset", int'(v), 0);
    rd(3'd1, v); chk("R1 cfg after reset", int'(v), 0);
    expect_shape(4, 2, "R4 bypass code 0");

    // R2: readback and field masking
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, v); chk("R2 cfg mask", int'(v), 32'h0010_371F);
    wr(3'd2, 32'h0000_015A);
    rd(3'd2, v); chk("R2 m readback", int'(v), 32'h5A);
    wr(3'd1, 32'h0000_0003);
    rd(3'd1, v); chk("R2 cfg readback", int'(v), 3);

    // R3: shadow write alone changes nothing
    expect_shape(4, 2, "R3 shadow isolated");
    wr(3'd0, 32'h1);
    rd(3'd0, v); chk("R3 request visible", int'(v[0]), 1);
    wait_done(200, ok); chk("R3 request clears", ok, 1);
    expect_shape(8, 4, "R4 code 3");

    wr(3'd1, 32'h0000_0004); wr(3'd0, 32'h1); wait_done(200, ok);
    expect_shape(10, 6, "R4 code 4 half ratio");
    wr(3'd1, 32'h0000_001F); wr(3'd0, 32'h1); wait_done(200, ok);
    expect_shape(64, 32, "R4 code 31");

    // R5: switch to source 3
    wr(3'd1, 32'h0000_0301); wr(3'd0, 32'h1); wait_done(400, ok);
    chk("R5 switch completes", ok, 1);
    expect_shape(10, 5, "R5 source 3");

    // R6: accumulator M=1 N=3 D=1, then M=3 N=4 D=2
    wr(3'd1, 32'h0000_2001); wr(3'd2, 32'h1); wr(3'd3, 32'hFD); wr(3'd4, 32'hFE);
    wr(3'd0, 32'h1); wait_done(400, ok);
    expect_shape(12, 4, "R6 m1 n3 d1");
    wr(3'd2, 32'h3); wr(3'd3, 32'hFE); wr(3'd4, 32'hFD);
    wr(3'd0, 32'h1); wait_done(400, ok);
    expect_shape(16, 8, "R6 m3 n4 d2");
    wr(3'd3, 32'hFF); wr(3'd0, 32'h1); wait_done(400, ok);
    expect_shape(4, 2, "R6 zero n-m bypass");
    wr(3'd3, 32'hFD); wr(3'd1, 32'h0000_0001); wr(3'd0, 32'h1); wait_done(400, ok);
    expect_shape(4, 2, "R6 mode 0 bypass");

    // R5/R8: new source stuck high blocks the handover
    freeze5 = 1'b1;
    wr(3'd1, 32'h0000_0501); wr(3'd0, 32'h1);
    wait_done(50, ok); chk("R5 waits for low source", ok, 0);
    rd(3'd0, v); chk("R8 root off during handover", int'(v[31]), 1);
    low_for(40, "R8 out held low");
    freeze5 = 1'b0;
    wait_done(400, ok); chk("R5 handover after release", ok, 1);
    rd(3'd0, v); chk("R8 root on after handover", int'(v[31]), 0);
    expect_shape(14, 7, "R5 source 5");

    // R7: hardware gating
    hw_req = 1'b0;
    wr(3'd1, 32'h0010_0001); wr(3'd0, 32'h1); wait_done(400, ok);
    rd(3'd0, v); chk("R7 root off when gated", int'(v[31]), 1);
    low_for(40, "R7 out held low");
    hw_req = 1'b1;
    rd(3'd0, v); chk("R7 root on with request", int'(v[31]), 0);
    expect_shape(4, 2, "R7 runs with request");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule